// File: doc/BRIEF.md
# Selectable-Field Packet Hasher

This preprocessing stage computes a 32-bit hash over a set of header bits that an upstream parser has gathered for the packet's data plane. The packet enters as a stream of 64-bit beats. Its first beat, marked by start-of-packet, is a control header that travels with the packet through the pipeline. Next to the beats the stage receives a 256-bit selected-bits vector and a 256-bit mask of the same width. The stage takes both on the start-of-packet beat, forces every bit whose mask bit is zero to zero, and runs a CRC-32 over the result. The CRC uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Bits are fed from bit 255 down to bit 0, with no reflection and no final inversion.

Software sets a per-plane register, and that register sets a hash-enable bit in the control header's module bitmap. When the bit is set, the stage writes the CRC into the header's hash field. When it is clear, the header goes through untouched. Every beat leaves the stage exactly eight cycles after it entered, so the header and its hash always come out together. The CRC work is split into eight 32-bit steps, one per pipeline stage, which lets a new packet start on every cycle.

Control-header layout used by the stage: bits [63:32] hold the hash field and bit 24 is the hash-enable bit. The stage does not interpret bits [31:0] and passes them through.

Top module: `pkt_field_hasher`

## Requirements
- R1: Every beat presented with in_valid high reappears on the outputs exactly 8 cycles later, with the same sop, eop and data values. Beats that are not start-of-packet leave with their data unchanged. Idle cycles stay idle.
- R2: On an output start-of-packet beat whose data bit 24 is 1, out_data[63:32] equals the CRC-32 of (sel_bits AND sel_mask) as captured on that packet's input start-of-packet beat. The CRC uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, feeds bits MSB first from bit 255 to bit 0, and has no reflection and no final XOR. out_data[31:0] equals the input header's bits [31:0].
- R3: Selected bits whose mask bit is 0 have no effect on the hash. Two packets that differ only in masked-off bits get identical hash fields. This includes a 240-bit selection that masks off the low 16 bits.
- R4: On a start-of-packet beat whose bit 24 is 0, the whole 64-bit header leaves unchanged, hash field included.
- R5: sel_bits and sel_mask matter only on the start-of-packet beat. Values presented on the later beats of the same packet do not change that packet's hash.
- R6: While rst_n is low, and on the first cycles after it is released, out_valid is 0.
- R7: Packets may arrive back to back, including single-beat packets on consecutive cycles and packets separated by idle cycles. Each packet gets the hash of its own selected bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input beat is the control header (first beat) |
| in_eop | input | 1 | Input beat is the last beat of the packet |
| in_data | input | 64 | Input beat data |
| sel_bits | input | 256 | Header bits gathered by the parser for hashing |
| sel_mask | input | 256 | 1 marks a bit of sel_bits that takes part in the hash |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output beat is the control header |
| out_eop | output | 1 | Output beat is the last beat |
| out_data | output | 64 | Output beat data, header carrying the hash |

## Verification
The hardest case to reach is a pipeline holding several packets at once, where each header must meet its own CRC state eight cycles after entry. A fault in the stage alignment only shows up when neighbouring packets carry different selected bits. The bench therefore sends single-beat packets on consecutive cycles, each with a distinct vector, and mixes in idle gaps and multi-beat packets. During the body beats it also drives sel_bits and sel_mask to unrelated values, so a design that samples them outside the start-of-packet beat produces a wrong hash.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
    localparam int BEAT_W = 64;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [BEAT_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/hsh_crc_step.sv
module hsh_crc_step #(
    parameter int          CRC_W = 32,
    parameter int          CHUNK = 32,
    parameter logic [31:0] POLY  = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [CHUNK-1:0] chunk,
    output logic [CRC_W-1:0] crc_out
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int i = CHUNK - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ chunk[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY[CRC_W-1:0];
        end
        crc_out = acc;
    end
endmodule

// File: rtl/hsh_hdr_merge.sv
module hsh_hdr_merge
    import hsh_pkg::*;
#(
    parameter int HASH_W   = 32,
    parameter int HASH_LSB = 32,
    parameter int EN_BIT   = 24
) (
    input  beat_t              beat,
    input  logic [HASH_W-1:0]  hash,
    output logic [BEAT_W-1:0]  data
);
    always_comb begin
        data = beat.data;
        if (beat.sop && beat.data[EN_BIT]) begin
            data[HASH_LSB +: HASH_W] = hash;
        end
    end
endmodule

// File: rtl/pkt_field_hasher.sv
module pkt_field_hasher
    import hsh_pkg::*;
#(
    parameter int          SEL_W    = 256,
    parameter int          CRC_W    = 32,
    parameter logic [31:0] POLY     = 32'h04C11DB7,
    parameter logic [31:0] INIT     = 32'hFFFFFFFF,
    parameter int          HASH_LSB = 32,
    parameter int          EN_BIT   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [63:0]       in_data,
    input  logic [SEL_W-1:0]  sel_bits,
    input  logic [SEL_W-1:0]  sel_mask,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [63:0]       out_data
);
    localparam int STAGES = 8;
    localparam int CHUNK  = SEL_W / STAGES;

    typedef struct packed {
        logic [STAGES-1:0]             vld;
        beat_t [STAGES-1:0]            beat;
        logic [STAGES-1:0][CRC_W-1:0]  crc;
        logic [STAGES-2:0][SEL_W-1:0]  rem;   // unconsumed bits, top-aligned
    } state_t;

    state_t state_d, state_q;

    logic [SEL_W-1:0] masked;
    beat_t            beat_in;
    logic [CRC_W-1:0] step_crc [STAGES];

    assign masked  = sel_bits & sel_mask;
    assign beat_in = '{sop: in_sop, eop: in_eop, data: in_data};

    // One CRC step per stage; stage 0 reads the live masked vector.
    for (genvar g = 0; g < STAGES; g++) begin : g_step
        logic [CRC_W-1:0] seed;
        logic [CHUNK-1:0] part;
        if (g == 0) begin : g_first
            assign seed = INIT[CRC_W-1:0];
            assign part = masked[SEL_W-1 -: CHUNK];
        end else begin : g_rest
            assign seed = state_q.crc[g-1];
            assign part = state_q.rem[g-1][SEL_W-1 -: CHUNK];
        end
        hsh_crc_step #(.CRC_W(CRC_W), .CHUNK(CHUNK), .POLY(POLY)) u_step (
            .crc_in (seed),
            .chunk  (part),
            .crc_out(step_crc[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.vld  = {state_q.vld[STAGES-2:0], in_valid};
        state_d.beat = {state_q.beat[STAGES-2:0], beat_in};
        // capture on start of packet, hold otherwise
        if (in_valid && in_sop) begin
            state_d.crc[0] = step_crc[0];
            state_d.rem[0] = masked << CHUNK;
        end
        for (int g = 1; g < STAGES; g++) begin
            state_d.crc[g] = step_crc[g];
        end
        for (int g = 1; g < STAGES - 1; g++) begin
            state_d.rem[g] = state_q.rem[g-1] << CHUNK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    hsh_hdr_merge #(.HASH_W(CRC_W), .HASH_LSB(HASH_LSB), .EN_BIT(EN_BIT)) u_merge (
        .beat(state_q.beat[STAGES-1]),
        .hash(state_q.crc[STAGES-1]),
        .data(out_data)
    );

    assign out_valid = state_q.vld[STAGES-1];
    assign out_sop   = state_q.beat[STAGES-1].sop;
    assign out_eop   = state_q.beat[STAGES-1].eop;
endmodule

// File: rtl/pkt_field_hasher_chk.sv
module pkt_field_hasher_chk #(
    parameter int EN_BIT = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sop,
    input logic        in_eop,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic        out_sop,
    input logic        out_eop,
    input logic [63:0] out_data
);
    localparam int LAT = 8;

    logic [LAT-1:0]       v_sh;
    logic [LAT-1:0]       s_sh;
    logic [LAT-1:0]       e_sh;
    logic [LAT-1:0][63:0] d_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sh <= '0;
            s_sh <= '0;
            e_sh <= '0;
            d_sh <= '0;
        end else begin
            v_sh <= {v_sh[LAT-2:0], in_valid};
            s_sh <= {s_sh[LAT-2:0], in_sop};
            e_sh <= {e_sh[LAT-2:0], in_eop};
            d_sh <= {d_sh[LAT-2:0], in_data};
        end
    end

    assert_reset_idle_R6: assert property (@(posedge clk) !rst_n |-> !out_valid);

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sh[LAT-1]);

    assert_flags_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == s_sh[LAT-1] && out_eop == e_sh[LAT-1]));

    assert_body_intact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> out_data == d_sh[LAT-1]);

    assert_low_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> out_data[31:0] == d_sh[LAT-1][31:0]);

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && !d_sh[LAT-1][EN_BIT]) |-> out_data == d_sh[LAT-1]);
endmodule

bind pkt_field_hasher pkt_field_hasher_chk #(.EN_BIT(EN_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_data (out_data)
);

// File: tb/pkt_field_hasher_test.sv
`timescale 1ns/1ps
module pkt_field_hasher_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [63:0]  in_data = '0;
    logic [255:0] sel_bits = '0, sel_mask = '0;
    logic         out_valid, out_sop, out_eop;
    logic [63:0]  out_data;

    int n_vec = 0;
    int n_bad = 0;

    logic [65:0] exp_a [0:255];
    logic [65:0] got_a [0:255];
    int exp_n = 0;
    int got_n = 0;

    always #2.5 clk = ~clk;

    pkt_field_hasher uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .sel_bits(sel_bits), .sel_mask(sel_mask),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (out_valid && got_n < 256) begin
            got_a[got_n] = {out_sop, out_eop, out_data};
            got_n++;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [255:0] v);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int i = 255; i >= 0; i--) begin
            fb = c[31] ^ v[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic send(input logic sop, input logic eop, input logic [63:0] d,
                        input logic [255:0] sb, input logic [255:0] sm);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        sel_bits = sb; sel_mask = sm;
        if (sop && d[24]) exp_a[exp_n] = {sop, eop, ref_crc(sb & sm), d[31:0]};
        else              exp_a[exp_n] = {sop, eop, d};
        exp_n++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
    endtask

    task automatic start_log();
        idle(1);
        exp_n = 0;
        got_n = 0;
    endtask

    task automatic compare(input string req);
        idle(12);
        check({req, " beat count"}, 66'(got_n), 66'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) check(req, got_a[i], exp_a[i]);
    endtask

    function automatic logic [255:0] pat(input int seed);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'h9E3779B9 * (seed * 8 + i + 1) ^ 32'h5A5A1234;
        return v;
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 in reset", {65'd0, out_valid}, 66'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after release", {65'd0, out_valid}, 66'd0);
    endtask

    task automatic t_latency();
        start_log();
        send(1'b1, 1'b1, 64'h0000_0000_0100_0ABC, pat(1), {256{1'b1}});
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            check($sformatf("R1 valid at cycle %0d", k), {65'd0, out_valid}, {65'd0, (k == 8)});
        end
        compare("R1 R2 single beat");
    endtask

    task automatic t_multi_beat();
        start_log();
        send(1'b1, 1'b0, 64'hFFFF_FFFF_0100_1111, pat(2), {256{1'b1}});
        send(1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, pat(2), {256{1'b1}});
        send(1'b0, 1'b1, 64'hFEDC_BA98_7654_3210, pat(2), {256{1'b1}});
        compare("R1 R2 multi beat");
    endtask

    task automatic t_disabled();
        start_log();
        send(1'b1, 1'b0, 64'hDEAD_BEEF_FEFF_2222, pat(3), {256{1'b1}});
        send(1'b0, 1'b1, 64'h1111_2222_3333_4444, pat(3), {256{1'b1}});
        compare("R4 enable clear");
    endtask

    task automatic t_mask();
        logic [255:0] m240;
        logic [63:0]  h1, h2;
        m240 = {{240{1'b1}}, 16'h0};
        start_log();
        send(1'b1, 1'b1, 64'h0000_0000_0100_0001, pat(4), m240);
        send(1'b1, 1'b1, 64'h0000_0000_0100_0002, pat(4) ^ 256'hFFFF, m240);
        send(1'b1, 1'b1, 64'h0000_0000_0100_0003, pat(5), '0);
        compare("R3 masked bits");
        h1 = got_a[0][63:0];
        h2 = got_a[1][63:0];
        check("R3 masked-off bits ignored", {34'd0, h1[63:32]}, {34'd0, h2[63:32]});
        check("R3 zero mask hash", {34'd0, got_a[2][63:32]}, {34'd0, ref_crc('0)});
    endtask

    task automatic t_sel_hold();
        start_log();
        send(1'b1, 1'b0, 64'h0000_0000_0100_0005, pat(6), {256{1'b1}});
        exp_a[0] = {1'b1, 1'b0, ref_crc(pat(6)), 32'h0100_0005};
        send(1'b0, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, pat(7), 256'h1);
        send(1'b0, 1'b1, 64'h5555_5555_5555_5555, ~pat(6), {256{1'b1}});
        compare("R5 selection held");
    endtask

    task automatic t_back_to_back();
        start_log();
        for (int p = 0; p < 10; p++) begin
            send(1'b1, 1'b1, {32'h0, 8'h01, 8'h00, 16'(p)}, pat(10 + p), {256{1'b1}} >> p);
        end
        idle(2);
        send(1'b1, 1'b0, 64'h0000_0000_0100_00AA, pat(30), {256{1'b1}});
        send(1'b0, 1'b1, 64'h0BAD_F00D_0000_0000, pat(31), {256{1'b1}});
        idle(1);
        send(1'b1, 1'b1, 64'h0000_0000_0100_00BB, pat(32), {{128{1'b1}}, 128'h0});
        compare("R7 back to back");
    endtask

    initial begin
        #1000000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_multi_beat();
        t_disabled();
        t_mask();
        t_sel_hold();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule